// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading translation tables held in ordinary memory. A 4-bit context number picks a word from a context table whose byte base arrives on a register input. That word points at a region table, which points at a segment table, which points at a page table. Every word fetched carries a two-bit type that either continues the walk or ends it.

The final page word holds the physical page number and a three-bit access code. The access code packs the user-mode rights and the supervisor-mode rights into one value. The walker checks the access code against the requester's privilege and against whether the access is a read or a write. On success it sets the referenced bit in the page word, and also the modified bit on a write. If either bit changed, it writes the word back before it answers.

A host puts one request on the request port and waits for a one-cycle response pulse. The response carries either a physical address or a fault with its level and cause. All table traffic goes through one word-wide memory master that holds each request until it is acknowledged.

Top module: `xw_walker`

## Requirements
- R1: While reset is low and on the first cycle after reset, `req_ready` is 1, `mem_req` is 0 and `rsp_valid` is 0.
- R2: The reads happen in a fixed order. The first read is at `ctx_base + 4*ctx`. The second is at `B1 + 4*va[31:24]`, the third at `B2 + 4*va[23:18]` and the fourth at `B3 + 4*va[17:12]`. Each base Bn is the previous word with bits 1:0 cleared, shifted left by 4 and zero-extended to 36 bits.
- R3: Bits 1:0 of each word give its type: 0 invalid, 1 table pointer, 2 page word, 3 reserved. At levels 0 to 2, any type other than 1 ends the walk with a fault. `rsp_level` is the level of that word (0 = context, 1 = region, 2 = segment). `rsp_cause` is 2 for type 3 and 1 otherwise.
- R4: At level 3, any type other than 2 ends the walk with a fault at level 3. The cause rule is the same as in R3.
- R5: The access code sits in bits 4:2 of the page word. A user access with code 6 or 7 faults with cause 3 at level 3.
- R6: A user write is allowed only with codes 1 and 3. A supervisor write is allowed with codes 1, 3, 5 and 7. A write that is not allowed faults with cause 3 at level 3, and no write-back takes place. Reads fault only under R5.
- R7: On success, `rsp_fault` is 0, `rsp_cause` is 0 and `rsp_level` is 3. `rsp_paddr` is page-word bits 31:8 followed by `va[11:0]`.
- R8: On success, the word written back is the page word with bit 5 set, and bit 6 also set on a write. It goes to the address the page word was read from. The walker writes only when this changes the word, and it writes exactly once.
- R9: `rsp_valid` is a single-cycle pulse. It arrives only after any write-back has been acknowledged. The response fields hold their values until the next response.
- R10: `mem_req` stays high with stable `mem_addr` and `mem_we` until `mem_ack` is seen. Each table word is read exactly once per walk, whatever the memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_base | input | 36 | Byte address of the context table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | 4 | Context number |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | 36 | Physical address on success |
| rsp_level | output | 2 | Level of the fault, 3 on success |
| rsp_cause | output | 2 | 0 none, 1 invalid, 2 reserved type, 3 protection |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 36 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
An accepted request raises `mem_req` on the next cycle. Each access then finishes in the cycle `mem_ack` rises. The walker either moves on or raises `rsp_valid` at the edge after that ack, so a response follows the last ack by exactly one edge. The bench memory varies its latency from walk to walk, so the bench does not count a fixed number of cycles. It samples on falling edges and polls for the response pulse. At that moment it checks that the logged read sequence and the write-back count are already final. It also checks that the fields still hold their values on the following cycle.

// File: rtl/xw_pkg.sv
package xw_pkg;
    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_TABLE   = 2'd1,
        ET_PAGE    = 2'd2,
        ET_RESV    = 2'd3
    } ent_e;

    typedef enum logic [1:0] {
        CZ_NONE     = 2'd0,
        CZ_INVALID  = 2'd1,
        CZ_RESERVED = 2'd2,
        CZ_PROT     = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WBACK = 2'd2
    } st_e;

    localparam int LAST_LVL  = 3;
    localparam int PE_REF    = 5;
    localparam int PE_MOD    = 6;
    localparam int PE_ACC_LO = 2;
    localparam int PE_PPN_LO = 8;
    localparam int DESC_SH   = 4;
endpackage

// File: rtl/xw_index.sv
module xw_index #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 36,
    parameter int CTX_W = 4,
    parameter int RG_LO = 24,
    parameter int SG_LO = 18,
    parameter int PG_LO = 12
) (
    input  logic [1:0]       lvl,
    input  logic [PA_W-1:0]  base,
    input  logic [CTX_W-1:0] ctx,
    input  logic [VA_W-1:0]  va,
    output logic [PA_W-1:0]  addr
);
    localparam int RG_W  = VA_W - RG_LO;
    localparam int IDX_W = (RG_W > CTX_W) ? RG_W : CTX_W;

    logic [IDX_W-1:0] idx;

    // one shared index mux and adder serves every level
    always_comb begin
        case (lvl)
            2'd0:    idx = IDX_W'(ctx);
            2'd1:    idx = IDX_W'(va[VA_W-1:RG_LO]);
            2'd2:    idx = IDX_W'(va[RG_LO-1:SG_LO]);
            default: idx = IDX_W'(va[SG_LO-1:PG_LO]);
        endcase
    end

    assign addr = base + PA_W'({idx, 2'b00});
endmodule

// File: rtl/xw_access.sv
module xw_access
    import xw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] ent,
    input  logic          user,
    input  logic          wr,
    output logic          deny,
    output logic [DW-1:0] ent_upd,
    output logic          dirty
);
    logic [2:0] code;
    logic       wr_ok;

    assign code = ent[PE_ACC_LO +: 3];

    always_comb begin
        if (user) wr_ok = (code == 3'd1) || (code == 3'd3);
        else      wr_ok = code[0];
        deny = (user && (code > 3'd5)) || (wr && !wr_ok);
    end

    always_comb begin
        ent_upd         = ent;
        ent_upd[PE_REF] = 1'b1;
        if (wr) ent_upd[PE_MOD] = 1'b1;
        dirty = (ent_upd != ent);
    end
endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 36,
    parameter int DW    = 32,
    parameter int CTX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  ctx_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [CTX_W-1:0] req_ctx,
    input  logic             req_user,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_level,
    output logic [1:0]       rsp_cause,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata
);
    localparam int RG_LO = VA_W - 8;
    localparam int SG_LO = RG_LO - 6;
    localparam int PG_LO = SG_LO - 6;

    typedef struct packed {
        st_e              st;
        logic [1:0]       lvl;
        logic [PA_W-1:0]  base;
        logic [VA_W-1:0]  va;
        logic [CTX_W-1:0] ctx;
        logic             user;
        logic             wr;
        logic [DW-1:0]    pte;
        logic             rsp_v;
        logic             rsp_f;
        logic [PA_W-1:0]  pa;
        logic [1:0]       rlvl;
        cause_e           cause;
    } regs_t;

    regs_t q, d;

    logic [PA_W-1:0] addr_w;
    logic            deny_w;
    logic            dirty_w;
    logic [DW-1:0]   upd_w;
    ent_e            etype;

    xw_index #(
        .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W),
        .RG_LO(RG_LO), .SG_LO(SG_LO), .PG_LO(PG_LO)
    ) u_index (
        .lvl (q.lvl),
        .base(q.base),
        .ctx (q.ctx),
        .va  (q.va),
        .addr(addr_w)
    );

    xw_access #(.DW(DW)) u_access (
        .ent    (mem_rdata),
        .user   (q.user),
        .wr     (q.wr),
        .deny   (deny_w),
        .ent_upd(upd_w),
        .dirty  (dirty_w)
    );

    assign etype = ent_e'(mem_rdata[1:0]);

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_FETCH;
                    d.lvl  = 2'd0;
                    d.base = ctx_base;
                    d.va   = req_vaddr;
                    d.ctx  = req_ctx;
                    d.user = req_user;
                    d.wr   = req_write;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    if (q.lvl != 2'(LAST_LVL)) begin
                        if (etype == ET_TABLE) begin
                            d.base = PA_W'({mem_rdata[DW-1:2], 2'b00}) << DESC_SH;
                            d.lvl  = q.lvl + 2'd1;
                        end else begin
                            d.st    = ST_IDLE;
                            d.rsp_v = 1'b1;
                            d.rsp_f = 1'b1;
                            d.rlvl  = q.lvl;
                            d.cause = (etype == ET_RESV) ? CZ_RESERVED : CZ_INVALID;
                        end
                    end else if (etype != ET_PAGE) begin
                        d.st    = ST_IDLE;
                        d.rsp_v = 1'b1;
                        d.rsp_f = 1'b1;
                        d.rlvl  = q.lvl;
                        d.cause = (etype == ET_RESV) ? CZ_RESERVED : CZ_INVALID;
                    end else if (deny_w) begin
                        d.st    = ST_IDLE;
                        d.rsp_v = 1'b1;
                        d.rsp_f = 1'b1;
                        d.rlvl  = q.lvl;
                        d.cause = CZ_PROT;
                    end else begin
                        d.pa    = PA_W'({mem_rdata[DW-1:PE_PPN_LO], q.va[PG_LO-1:0]});
                        d.pte   = upd_w;
                        d.rsp_f = 1'b0;
                        d.rlvl  = q.lvl;
                        d.cause = CZ_NONE;
                        if (dirty_w) begin
                            d.st = ST_WBACK;
                        end else begin
                            d.st    = ST_IDLE;
                            d.rsp_v = 1'b1;
                        end
                    end
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    d.st    = ST_IDLE;
                    d.rsp_v = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.st == ST_IDLE);
    assign mem_req   = (q.st == ST_FETCH) || (q.st == ST_WBACK);
    assign mem_we    = (q.st == ST_WBACK);
    assign mem_addr  = addr_w;
    assign mem_wdata = q.pte;
    assign rsp_valid = q.rsp_v;
    assign rsp_fault = q.rsp_f;
    assign rsp_paddr = q.pa;
    assign rsp_level = q.rlvl;
    assign rsp_cause = q.cause;
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk #(
    parameter int PA_W = 36,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [PA_W-1:0] mem_addr,
    input logic [DW-1:0]   mem_wdata,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [1:0]      rsp_level,
    input logic [1:0]      rsp_cause
);
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_wback_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[5] && (mem_wdata[1:0] == 2'b10)));

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    assert_prot_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && (rsp_cause == 2'd3)) |-> (rsp_level == 2'd3));

    assert_ok_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> ((rsp_cause == 2'd0) && (rsp_level == 2'd3)));
endmodule

bind xw_walker xw_walker_chk #(.PA_W(PA_W), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault),
    .rsp_level(rsp_level),
    .rsp_cause(rsp_cause)
);

// File: tb/tb_xw_walker.sv
`timescale 1ns/1ps
module tb_xw_walker;
    localparam logic [35:0] CB = 36'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] ctx_base = CB;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [3:0]  req_ctx = '0;
    logic        req_user = 1'b0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [35:0] rsp_paddr;
    logic [1:0]  rsp_level, rsp_cause;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    xw_walker dut (
        .clk(clk), .rst_n(rst_n), .ctx_base(ctx_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_ctx(req_ctx), .req_user(req_user), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_level(rsp_level), .rsp_cause(rsp_cause),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem [0:4095];
    logic [35:0] rd_log [0:63];
    int          rd_n = 0, wr_n = 0, wcnt = 0, lat = 0, oob = 0;
    logic [35:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    int          checks = 0, fails = 0;

    initial for (int i = 0; i < 4096; i++) mem[i] = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt = 0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt >= lat) begin
                wcnt = 0;
                mem_ack <= 1'b1;
                if (mem_addr[35:14] != 0) oob++;
                if (mem_we) begin
                    mem[mem_addr[13:2]] = mem_wdata;
                    wr_addr = mem_addr;
                    wr_data = mem_wdata;
                    wr_n++;
                end else begin
                    mem_rdata <= mem[mem_addr[13:2]];
                    rd_log[rd_n % 64] = mem_addr;
                    rd_n++;
                end
            end else begin
                wcnt++;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ent_idx(input int l, input logic [31:0] va, input logic [3:0] ctx);
        case (l)
            0:       return int'(CB >> 2) + int'(ctx);
            1:       return 256 + int'(va[31:24]);
            2:       return 512 + int'(va[23:18]);
            default: return 576 + int'(va[17:12]);
        endcase
    endfunction

    task automatic build(input logic [31:0] va, input logic [3:0] ctx, input logic [31:0] pte);
        mem[ent_idx(0, va, ctx)] = 32'h41;
        mem[ent_idx(1, va, ctx)] = 32'h81;
        mem[ent_idx(2, va, ctx)] = 32'h91;
        mem[ent_idx(3, va, ctx)] = pte;
    endtask

    task automatic walk(input logic [31:0] va, input logic [3:0] ctx, input bit u, input bit w,
                        output bit to);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_ctx = ctx; req_user = u; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        to = !rsp_valid;
    endtask

    task automatic finish_run();
        if (oob != 0) chk("R2 addresses inside memory", 64'(oob), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit to;
        int r0, w0;
        logic [31:0] va, pte;
        logic [3:0]  ctx;
        logic [35:0] held_pa;

        repeat (3) @(negedge clk);
        chk("R1 ready in reset", 64'(req_ready), 64'd1);
        chk("R1 no mem req in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        chk("R1 no mem req after reset", 64'(mem_req), 64'd0);
        chk("R1 no rsp after reset", 64'(rsp_valid), 64'd0);

        // type sweep at each level (R3 for levels 0..2, R4 for level 3)
        for (int l = 0; l < 4; l++) begin
            for (int t = 0; t < 4; t++) begin
                if ((l < 3 && t == 1) || (l == 3 && t == 2)) continue;
                va  = {8'(8'h11 * (l + 1)), 6'(t * 9 + 3), 6'(l * 13 + t), 12'h3c5};
                ctx = 4'(l * 4 + t);
                build(va, ctx, {24'h0abcde, 8'b0000_1110});
                mem[ent_idx(l, va, ctx)] = {mem[ent_idx(l, va, ctx)][31:2], 2'(t)};
                lat = t % 3;
                r0 = rd_n; w0 = wr_n;
                walk(va, ctx, 1'b0, 1'b0, to);
                chk(l < 3 ? "R3 fault timeout" : "R4 fault timeout", 64'(to), 64'd0);
                chk(l < 3 ? "R3 fault flag" : "R4 fault flag", 64'(rsp_fault), 64'd1);
                chk(l < 3 ? "R3 fault level" : "R4 fault level", 64'(rsp_level), 64'(l));
                chk(l < 3 ? "R3 fault cause" : "R4 fault cause", 64'(rsp_cause), (t == 3) ? 64'd2 : 64'd1);
                chk("R10 reads up to fault", 64'(rd_n - r0), 64'(l + 1));
                chk("R8 no write on fault", 64'(wr_n - w0), 64'd0);
            end
        end

        // access code / mode / direction / prior bits sweep
        for (int it = 0; it < 128; it++) begin
            bit u, w, cb, pm, pr, pf, expwb;
            logic [2:0]  code;
            logic [23:0] ppn;
            logic [31:0] upd;
            code = 3'(it >> 4);
            u = it[3]; w = it[2]; pm = it[1]; pr = it[0];
            cb  = it[4] ^ it[0];
            ppn = 24'ha50000 + 24'(it * 24'h1357);
            pte = {ppn, cb, pm, pr, code, 2'b10};
            va  = {8'(it * 7 + 1), 6'(it * 3), 6'(it * 5 + 2), 12'(it * 37)};
            ctx = 4'(it);
            build(va, ctx, pte);
            lat = it % 3;
            pf = (u && code > 3'd5) || (w && !(u ? (code == 3'd1 || code == 3'd3) : code[0]));
            upd = pte | 32'h20 | (w ? 32'h40 : 32'h0);
            expwb = !pf && (upd != pte);
            r0 = rd_n; w0 = wr_n;
            walk(va, ctx, u, w, to);
            chk("R9 response timeout", 64'(to), 64'd0);
            chk("R10 four reads", 64'(rd_n - r0), 64'd4);
            chk("R2 context read addr", 64'(rd_log[r0 % 64]), 64'(CB + 36'(4 * ctx)));
            chk("R2 region read addr", 64'(rd_log[(r0 + 1) % 64]), 64'(36'h400 + 36'(4 * va[31:24])));
            chk("R2 segment read addr", 64'(rd_log[(r0 + 2) % 64]), 64'(36'h800 + 36'(4 * va[23:18])));
            chk("R2 page read addr", 64'(rd_log[(r0 + 3) % 64]), 64'(36'h900 + 36'(4 * va[17:12])));
            if (u && code > 3'd5) begin
                chk("R5 user prot fault", 64'(rsp_fault), 64'd1);
                chk("R5 prot cause", 64'(rsp_cause), 64'd3);
                chk("R5 prot level", 64'(rsp_level), 64'd3);
            end else begin
                chk("R6 write right", 64'(rsp_fault), 64'(pf));
                if (pf) chk("R6 prot cause", 64'(rsp_cause), 64'd3);
            end
            if (!pf) begin
                chk("R7 paddr", 64'(rsp_paddr), 64'({ppn, va[11:0]}));
                chk("R7 ok cause", 64'(rsp_cause), 64'd0);
                chk("R7 ok level", 64'(rsp_level), 64'd3);
            end
            chk("R8 write-back count before rsp (R9)", 64'(wr_n - w0), 64'(expwb));
            if (expwb) begin
                chk("R8 write-back data", 64'(wr_data), 64'(upd));
                chk("R8 write-back addr", 64'(wr_addr), 64'(36'h900 + 36'(4 * va[17:12])));
                chk("R8 memory updated", 64'(mem[ent_idx(3, va, ctx)]), 64'(upd));
            end
            held_pa = rsp_paddr;
            @(negedge clk);
            chk("R9 single pulse", 64'(rsp_valid), 64'd0);
            chk("R9 fields held", 64'(rsp_paddr), 64'(held_pa));
        end

        finish_run();
    end
endmodule